// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver with Format Lock

The block is a full-duplex asynchronous serial port. A transmitter serialises a byte handed over on a valid/ready handshake. A receiver rebuilds bytes from the serial input line. One format register sets the frame layout for both directions:

- the character length, 7 or 8 bits;
- one or two stop bits on transmit;
- the bit order, most significant or least significant bit first;
- one of four parity modes.

A separate enable register holds three bits: power, transmit enable and receive enable. Baud timing comes from outside as a one-cycle tick enable that runs at 16 times the bit rate.

The format register can only be changed while the port is idle. It takes writes when power is off, or when both directions are disabled. Any other write is dropped without effect. This keeps the layout fixed for the whole of every frame in flight.

Besides odd and even parity, the port has a forced-zero parity mode. In that mode the transmitter sends a parity bit that is always 0. The receiver expects a parity bit in that position but never checks it. Each received character comes with a one-cycle valid strobe and three flags:
- a parity error flag;
- a framing error flag, for a bad first stop bit;
- an overrun flag, for a character that arrived before the previous one was read.

Top module: `uart_fmt_xcvr`

## Requirements
- R1: The format register (`fmt_wdata`/`fmt_rdata`) has this layout: bits [1:0] parity mode, bit 2 character length, bit 3 stop length, bit 4 bit order. A write takes effect only when the power bit is 0, or when the transmit and receive enable bits are both 0. Any other write leaves `fmt_rdata` unchanged. The enable register (`en_wdata`) can be written at any time: bit 0 is power, bit 1 transmit enable, bit 2 receive enable.
- R2: Each transmitted frame has the following bits, each lasting 16 ticks:
  - a start bit of 0;
  - the data bits, 7 of them when the character-length bit is 0 and 8 when it is 1;
  - the parity bit, if there is one;
  - stop bits of 1.

  The data bits are sent least significant first when the order bit is 1, and most significant first when it is 0.
- R3: Transmit parity code 00 sends no parity bit, 01 a parity bit of 0, 10 odd parity and 11 even parity. Odd and even parity are taken over the data bits actually sent.
- R4: A transmitted frame has 1 stop bit when the stop-length bit is 0 and 2 when it is 1. `tx_ready` returns high exactly 16 × (frame length in bits) clock cycles after the accepting edge, with the tick held high.
- R5: `tx_ready` is high only while power and transmit enable are both 1 and no frame is in progress. `txd` idles at 1. In 7-bit mode, bit 7 of `tx_data` has no effect on the frame.
- R6: The receiver places data bits according to the order bit and the character length. In 7-bit mode `rx_data[7]` is 0.
- R7: On receive, parity code 00 expects no parity bit. Code 01 expects a parity bit and never raises `rx_perr`, whatever its value. Codes 10 and 11 raise `rx_perr` when the bit does not give odd or even parity respectively.
- R8: `rx_ferr` is set with a character whose first stop bit samples 0, and clear when it samples 1.
- R9: `rx_valid` is a one-cycle strobe. `rx_oerr` is set with a character that completes while the previous one is still unread (no `rx_rd` since its strobe). The new character replaces the old one.
- R10: A low pulse on `rxd` that has ended by the middle of the start bit (8 ticks) produces no character.
- R11: After reset:
  - `txd` is 1;
  - `tx_ready` and `rx_valid` are 0;
  - the enable register is 0;
  - the format register reads 0x14, which is 8 data bits, least significant first, no parity and one stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 3 | Enable bits: [0] power, [1] transmit, [2] receive |
| fmt_wr | input | 1 | Format register write strobe |
| fmt_wdata | input | 5 | Format write value |
| fmt_rdata | output | 5 | Current format register |
| tick16 | input | 1 | Oversampling tick, 16 per bit |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmitter accepts a byte |
| txd | output | 1 | Serial output line |
| rxd | input | 1 | Serial input line |
| rx_rd | input | 1 | Consumer has read the received byte |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle strobe: new byte |
| rx_perr | output | 1 | Parity error of this byte |
| rx_ferr | output | 1 | Framing error of this byte |
| rx_oerr | output | 1 | Overrun on this byte |

## Verification
The bench sweeps all 32 format codes in both directions, and decodes or builds every frame from its own bit-position arithmetic. An error in bit order or 7-bit masking would garble bytes. A wrong parity polarity would flag good frames, and a zero-parity mode that still checked parity would flag frames carrying a parity bit of 1. An off-by-one in the stop count shows up in the cycle at which `tx_ready` returns.

Further cases each target one specific error:
- Writes during each locked combination of enable bits: a lock decoded from the wrong bits would let the format change.
- A first stop bit held low: a receiver that ignored it would fail to flag the frame.
- Two unread characters: a receiver that failed to track the unread byte would miss the overrun.
- A start-bit glitch: a receiver that did not re-check mid-start would produce a phantom byte.

// File: rtl/uart_fmt_pkg.sv
package uart_fmt_pkg;

    localparam int DW      = 8;
    localparam int FRAME_W = 1 + DW + 1 + 2;
    localparam int LEN_W   = $clog2(FRAME_W + 1);
    localparam int BW      = $clog2(DW);

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_ZERO = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_EVEN = 2'b11
    } par_mode_e;

    typedef struct packed {
        logic      lsb_first;
        logic      stop2;
        logic      char8;
        par_mode_e par;
    } fmt_t;

    typedef struct packed {
        logic rx_en;
        logic tx_en;
        logic power;
    } en_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;

    localparam fmt_t FMT_RESET = '{lsb_first: 1'b1, stop2: 1'b0, char8: 1'b1, par: PAR_NONE};

    // Clear the top bit for 7-bit characters
    function automatic logic [DW-1:0] mask_char(input logic [DW-1:0] d, input logic char8);
        logic [DW-1:0] m;
        m = d;
        if (!char8) m[DW-1] = 1'b0;
        return m;
    endfunction

    // Bit k of the result is the k-th bit on the line; self-inverse
    function automatic logic [DW-1:0] order_bits(input logic [DW-1:0] d, input logic char8,
                                                 input logic lsb_first);
        logic [DW-1:0] m;
        logic [DW-1:0] o;
        int            n;
        m = mask_char(d, char8);
        n = char8 ? DW : DW - 1;
        o = '0;
        if (lsb_first) begin
            o = m;
        end else begin
            for (int k = 0; k < DW; k++) begin
                if (k < n) o[k] = m[n-1-k];
            end
        end
        return o;
    endfunction

    function automatic logic par_bit(input logic [DW-1:0] m, input par_mode_e p);
        case (p)
            PAR_ODD:  return ~(^m);
            PAR_EVEN: return ^m;
            default:  return 1'b0;
        endcase
    endfunction

    // Frame as sent: bit 0 first, unused upper bits are idle/stop ones
    function automatic logic [FRAME_W-1:0] build_frame(input logic [DW-1:0] d, input fmt_t f);
        logic [FRAME_W-1:0] fr;
        logic [DW-1:0]      m;
        logic [DW-1:0]      o;
        int                 n;
        fr    = '1;
        fr[0] = 1'b0;
        m     = mask_char(d, f.char8);
        o     = order_bits(d, f.char8, f.lsb_first);
        n     = f.char8 ? DW : DW - 1;
        for (int k = 0; k < DW; k++) begin
            if (k < n) fr[1+k] = o[k];
        end
        if (f.par != PAR_NONE) fr[1+n] = par_bit(m, f.par);
        return fr;
    endfunction

    function automatic logic [LEN_W-1:0] frame_len(input fmt_t f);
        int l;
        l = 1 + (f.char8 ? DW : DW - 1) + ((f.par != PAR_NONE) ? 1 : 0) + (f.stop2 ? 2 : 1);
        return LEN_W'(l);
    endfunction

endpackage

// File: rtl/uart_fmt_ctrl.sv
module uart_fmt_ctrl
    import uart_fmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en_wr,
    input  logic [2:0] en_wdata,
    input  logic       fmt_wr,
    input  logic [4:0] fmt_wdata,
    output en_t        en_q,
    output fmt_t       fmt_q
);

    logic locked;

    assign locked = en_q.power && (en_q.tx_en || en_q.rx_en);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            fmt_q <= FMT_RESET;
        end else begin
            if (en_wr)              en_q  <= en_t'(en_wdata);
            if (fmt_wr && !locked)  fmt_q <= fmt_t'(fmt_wdata);
        end
    end

endmodule

// File: rtl/uart_fmt_tx.sv
module uart_fmt_tx
    import uart_fmt_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic          tick,
    input  fmt_t          fmt,
    input  logic [DW-1:0] data,
    input  logic          valid,
    output logic          ready,
    output logic          txd
);

    localparam int CW = $clog2(OSR);

    logic               busy;
    logic [FRAME_W-1:0] sh;
    logic [CW-1:0]      tcnt;
    logic [LEN_W-1:0]   left;

    assign ready = active && !busy;
    assign txd   = busy ? sh[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            busy <= 1'b0;
            sh   <= '1;
            tcnt <= '0;
            left <= '0;
        end else if (valid && ready) begin
            busy <= 1'b1;
            sh   <= build_frame(data, fmt);
            tcnt <= '0;
            left <= frame_len(fmt);
        end else if (busy && tick) begin
            if (tcnt == CW'(OSR - 1)) begin
                tcnt <= '0;
                sh   <= {1'b1, sh[FRAME_W-1:1]};
                left <= left - 1'b1;
                if (left == LEN_W'(1)) busy <= 1'b0;
            end else begin
                tcnt <= tcnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/uart_fmt_rx.sv
module uart_fmt_rx
    import uart_fmt_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic          tick,
    input  fmt_t          fmt,
    input  logic          rxd,
    output logic          done,
    output logic [DW-1:0] data,
    output logic          perr,
    output logic          ferr
);

    localparam int CW  = $clog2(OSR);
    localparam int MID = OSR / 2 - 1;

    logic          s1, s2;
    rx_state_e     state;
    logic [CW-1:0] cnt;
    logic [BW-1:0] bidx;
    logic [BW-1:0] last_idx;
    logic [DW-1:0] bits;
    logic          pbit;
    logic          full_bit;
    logic          chk_par;

    assign last_idx = fmt.char8 ? BW'(DW - 1) : BW'(DW - 2);
    assign full_bit = (cnt == CW'(OSR - 1));
    assign chk_par  = (fmt.par == PAR_ODD) || (fmt.par == PAR_EVEN);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= rxd;
            s2 <= s1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            state <= RX_IDLE;
            cnt   <= '0;
            bidx  <= '0;
            bits  <= '0;
            pbit  <= 1'b0;
            done  <= 1'b0;
            data  <= '0;
            perr  <= 1'b0;
            ferr  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                case (state)
                    RX_IDLE: begin
                        if (!s2) begin
                            state <= RX_START;
                            cnt   <= '0;
                        end
                    end
                    RX_START: begin
                        if (cnt == CW'(MID)) begin
                            cnt <= '0;
                            if (!s2) begin
                                state <= RX_DATA;
                                bidx  <= '0;
                                bits  <= '0;
                            end else begin
                                state <= RX_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (full_bit) begin
                            cnt        <= '0;
                            bits[bidx] <= s2;
                            if (bidx == last_idx) begin
                                state <= (fmt.par != PAR_NONE) ? RX_PAR : RX_STOP;
                            end else begin
                                bidx <= bidx + 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_PAR: begin
                        if (full_bit) begin
                            cnt   <= '0;
                            pbit  <= s2;
                            state <= RX_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (full_bit) begin
                            cnt   <= '0;
                            state <= RX_IDLE;
                            done  <= 1'b1;
                            data  <= order_bits(bits, fmt.char8, fmt.lsb_first);
                            perr  <= chk_par && (pbit != par_bit(bits, fmt.par));
                            ferr  <= !s2;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/uart_fmt_xcvr.sv
module uart_fmt_xcvr
    import uart_fmt_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en_wr,
    input  logic [2:0] en_wdata,
    input  logic       fmt_wr,
    input  logic [4:0] fmt_wdata,
    output logic [4:0] fmt_rdata,
    input  logic       tick16,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    output logic       tx_ready,
    output logic       txd,
    input  logic       rxd,
    input  logic       rx_rd,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    output logic       rx_perr,
    output logic       rx_ferr,
    output logic       rx_oerr
);

    en_t           en_q;
    fmt_t          fmt_q;
    logic          pwr_on, tx_on, rx_on;
    logic          rx_done;
    logic [DW-1:0] rx_word;
    logic          rx_pe, rx_fe;
    logic          rx_full;

    assign pwr_on    = en_q.power;
    assign tx_on     = en_q.power && en_q.tx_en;
    assign rx_on     = en_q.power && en_q.rx_en;
    assign fmt_rdata = fmt_q;

    uart_fmt_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .en_wr     (en_wr),
        .en_wdata  (en_wdata),
        .fmt_wr    (fmt_wr),
        .fmt_wdata (fmt_wdata),
        .en_q      (en_q),
        .fmt_q     (fmt_q)
    );

    uart_fmt_tx #(.OSR(OSR)) u_tx (
        .clk    (clk),
        .rst    (rst),
        .active (tx_on),
        .tick   (tick16),
        .fmt    (fmt_q),
        .data   (tx_data),
        .valid  (tx_valid),
        .ready  (tx_ready),
        .txd    (txd)
    );

    uart_fmt_rx #(.OSR(OSR)) u_rx (
        .clk    (clk),
        .rst    (rst),
        .active (rx_on),
        .tick   (tick16),
        .fmt    (fmt_q),
        .rxd    (rxd),
        .done   (rx_done),
        .data   (rx_word),
        .perr   (rx_pe),
        .ferr   (rx_fe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_valid <= 1'b0;
            rx_data  <= '0;
            rx_perr  <= 1'b0;
            rx_ferr  <= 1'b0;
            rx_oerr  <= 1'b0;
            rx_full  <= 1'b0;
        end else begin
            rx_valid <= rx_done;
            if (rx_done) begin
                rx_data <= rx_word;
                rx_perr <= rx_pe;
                rx_ferr <= rx_fe;
                rx_oerr <= rx_full && !rx_rd;
                rx_full <= 1'b1;
            end else if (rx_rd) begin
                rx_full <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/uart_fmt_chk.sv
module uart_fmt_chk (
    input logic       clk,
    input logic       rst,
    input logic       pwr,
    input logic       txe,
    input logic       rxe,
    input logic       fmt_wr,
    input logic [4:0] fmt_rdata,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       txd,
    input logic       rx_valid,
    input logic [7:0] rx_data,
    input logic       rx_perr
);

    p_lock_r1: assert property (@(posedge clk) disable iff (rst)
        (fmt_wr && pwr && (txe || rxe)) |=> $stable(fmt_rdata));

    p_start_bit_r2: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> !txd);

    p_ready_gate_r5: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> (pwr && txe));

    p_txd_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !(pwr && txe) |=> txd);

    p_msb_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !fmt_rdata[2]) |-> !rx_data[7]);

    p_zero_par_r7: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && fmt_rdata[1:0] == 2'b01) |-> !rx_perr);

    p_no_par_r7: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && fmt_rdata[1:0] == 2'b00) |-> !rx_perr);

    p_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

endmodule

bind uart_fmt_xcvr uart_fmt_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .pwr       (pwr_on),
    .txe       (tx_on),
    .rxe       (rx_on),
    .fmt_wr    (fmt_wr),
    .fmt_rdata (fmt_rdata),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .txd       (txd),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .rx_perr   (rx_perr)
);

// File: tb/tb_uart_fmt_xcvr.sv
module tb_uart_fmt_xcvr;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en_wr = 1'b0;
    logic [2:0] en_wdata = '0;
    logic       fmt_wr = 1'b0;
    logic [4:0] fmt_wdata = '0;
    logic [4:0] fmt_rdata;
    logic       tick16 = 1'b1;
    logic [7:0] tx_data = '0;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic       txd;
    logic       rxd = 1'b1;
    logic       rx_rd = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_perr, rx_ferr, rx_oerr;

    int checks = 0;
    int fails  = 0;
    int cap_cnt = 0;
    logic [7:0] cap_data;
    logic       cap_pe, cap_fe, cap_oe;

    always #(CLK_P/2) clk = ~clk;

    uart_fmt_xcvr dut (
        .clk(clk), .rst(rst), .en_wr(en_wr), .en_wdata(en_wdata),
        .fmt_wr(fmt_wr), .fmt_wdata(fmt_wdata), .fmt_rdata(fmt_rdata),
        .tick16(tick16), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .txd(txd), .rxd(rxd), .rx_rd(rx_rd), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_oerr(rx_oerr)
    );

    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            cap_cnt  <= cap_cnt + 1;
            cap_data <= rx_data;
            cap_pe   <= rx_perr;
            cap_fe   <= rx_ferr;
            cap_oe   <= rx_oerr;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic wr_en(input logic [2:0] v);
        @(negedge clk); en_wr = 1'b1; en_wdata = v;
        @(negedge clk); en_wr = 1'b0;
    endtask

    task automatic wr_fmt(input logic [4:0] v);
        @(negedge clk); fmt_wr = 1'b1; fmt_wdata = v;
        @(negedge clk); fmt_wr = 1'b0;
    endtask

    task automatic read_rx();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    // Bench model of the frame: fields [1:0] parity, [2] 8-bit, [3] two stops, [4] LSB first
    function automatic int nbits(input logic [4:0] f);
        return f[2] ? 8 : 7;
    endfunction

    function automatic int flen(input logic [4:0] f);
        return 1 + nbits(f) + ((f[1:0] != 2'b00) ? 1 : 0) + (f[3] ? 2 : 1);
    endfunction

    function automatic logic fbit(input logic [4:0] f, input logic [7:0] d, input int k);
        int n, ones;
        n = nbits(f);
        if (k == 0) return 1'b0;
        if (k <= n) return f[4] ? d[k-1] : d[n-k];
        if (k == n + 1 && f[1:0] != 2'b00) begin
            ones = 0;
            for (int i = 0; i < n; i++) ones += int'(d[i]);
            if (f[1:0] == 2'b01) return 1'b0;
            if (f[1:0] == 2'b10) return (ones % 2) == 0;
            return (ones % 2) == 1;
        end
        return 1'b1;
    endfunction

    task automatic tx_frame(input logic [4:0] f, input logic [7:0] d);
        int bad;
        int len;
        bad = 0;
        len = flen(f);
        @(negedge clk);
        chk("R5 tx_ready idle", {31'd0, tx_ready}, 32'd1);
        tx_valid = 1'b1; tx_data = d;
        @(posedge clk);
        #1 tx_valid = 1'b0;
        for (int k = 0; k < len; k++) begin
            repeat ((k == 0) ? 8 : 16) @(posedge clk);
            #1 if (txd !== fbit(f, d, k)) bad++;
        end
        chk($sformatf("R2 R3 tx frame fmt=%0h data=%0h", f, d), bad, 0);
        repeat (7) @(posedge clk);
        #1 chk("R4 tx_ready low before frame end", {31'd0, tx_ready}, 32'd0);
        @(posedge clk);
        #1 chk("R4 tx_ready back at frame end", {31'd0, tx_ready}, 32'd1);
    endtask

    task automatic rx_frame(input logic [4:0] f, input logic [7:0] d,
                            input bit bad_par, input bit bad_stop);
        int len, n;
        logic b;
        len = flen(f);
        n = nbits(f);
        for (int k = 0; k < len; k++) begin
            b = fbit(f, d, k);
            if (bad_par && f[1:0] != 2'b00 && k == n + 1) b = ~b;
            @(negedge clk);
            if (bad_stop && k == (len - (f[3] ? 2 : 1))) begin
                rxd = 1'b0;
                repeat (10) @(negedge clk);
                rxd = 1'b1;
                repeat (5) @(negedge clk);
            end else begin
                rxd = b;
                repeat (15) @(negedge clk);
            end
        end
        @(negedge clk); rxd = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    task automatic rx_check(input string tag, input logic [4:0] f, input logic [7:0] d,
                            input int cnt0, input bit exp_pe, input bit exp_fe, input bit exp_oe);
        logic [7:0] ed;
        ed = f[2] ? d : {1'b0, d[6:0]};
        chk({tag, " R6 one char received"}, cap_cnt - cnt0, 1);
        chk($sformatf("%s R6 rx data fmt=%0h", tag, f), cap_data, ed);
        chk({tag, " R7 parity flag"}, {31'd0, cap_pe}, {31'd0, exp_pe});
        chk({tag, " R8 framing flag"}, {31'd0, cap_fe}, {31'd0, exp_fe});
        chk({tag, " R9 overrun flag"}, {31'd0, cap_oe}, {31'd0, exp_oe});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] dv [4];
        int c0;
        dv[0] = 8'h5A; dv[1] = 8'hC3; dv[2] = 8'h80; dv[3] = 8'h7E;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11 txd idle", {31'd0, txd}, 32'd1);
        chk("R11 tx_ready", {31'd0, tx_ready}, 32'd0);
        chk("R11 rx_valid", {31'd0, rx_valid}, 32'd0);
        chk("R11 format reset", {27'd0, fmt_rdata}, 32'h14);

        // R1 lock behaviour
        wr_en(3'b011);
        wr_fmt(5'h0B);
        chk("R1 locked with tx enabled", {27'd0, fmt_rdata}, 32'h14);
        wr_en(3'b101);
        wr_fmt(5'h0B);
        chk("R1 locked with rx enabled", {27'd0, fmt_rdata}, 32'h14);
        wr_en(3'b001);
        wr_fmt(5'h0B);
        chk("R1 open with both disabled", {27'd0, fmt_rdata}, 32'h0B);
        wr_en(3'b110);
        wr_fmt(5'h14);
        chk("R1 open with power off", {27'd0, fmt_rdata}, 32'h14);

        // R5 ready gating
        wr_en(3'b101);
        @(negedge clk);
        chk("R5 tx_ready without tx enable", {31'd0, tx_ready}, 32'd0);
        chk("R5 txd idle", {31'd0, txd}, 32'd1);
        wr_en(3'b010);
        @(negedge clk);
        chk("R5 tx_ready without power", {31'd0, tx_ready}, 32'd0);

        // Sweep every format in both directions
        for (int f = 0; f < 32; f++) begin
            wr_en(3'b000);
            wr_fmt(5'(f));
            wr_en(3'b111);
            chk("R1 format written", {27'd0, fmt_rdata}, f);
            for (int i = 0; i < 4; i++) begin
                tx_frame(5'(f), dv[i]);
                c0 = cap_cnt;
                rx_frame(5'(f), dv[i], i == 1, 1'b0);
                rx_check("sweep", 5'(f), dv[i], c0,
                         (i == 1) && (f[1:0] == 2'b10 || f[1:0] == 2'b11), 1'b0, 1'b0);
                read_rx();
            end
        end

        // R7 zero-parity mode with parity bit 1
        wr_en(3'b000);
        wr_fmt(5'b10101);
        wr_en(3'b111);
        c0 = cap_cnt;
        rx_frame(5'b10101, 8'h33, 1'b1, 1'b0);
        rx_check("zero-parity R7", 5'b10101, 8'h33, c0, 1'b0, 1'b0, 1'b0);
        read_rx();

        // R8 framing error
        c0 = cap_cnt;
        rx_frame(5'b10101, 8'h96, 1'b0, 1'b1);
        rx_check("bad stop R8", 5'b10101, 8'h96, c0, 1'b0, 1'b1, 1'b0);
        read_rx();

        // R9 overrun
        c0 = cap_cnt;
        rx_frame(5'b10101, 8'h11, 1'b0, 1'b0);
        rx_check("first R9", 5'b10101, 8'h11, c0, 1'b0, 1'b0, 1'b0);
        c0 = cap_cnt;
        rx_frame(5'b10101, 8'h22, 1'b0, 1'b0);
        rx_check("unread R9", 5'b10101, 8'h22, c0, 1'b0, 1'b0, 1'b1);
        read_rx();
        c0 = cap_cnt;
        rx_frame(5'b10101, 8'h44, 1'b0, 1'b0);
        rx_check("after read R9", 5'b10101, 8'h44, c0, 1'b0, 1'b0, 1'b0);
        read_rx();

        // R10 start glitch
        c0 = cap_cnt;
        @(negedge clk); rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (300) @(negedge clk);
        chk("R10 glitch gives no character", cap_cnt - c0, 0);
        rx_frame(5'b10101, 8'h5C, 1'b0, 1'b0);
        rx_check("post-glitch R10", 5'b10101, 8'h5C, c0, 1'b0, 1'b0, 1'b0);

        finish_run();
    end

endmodule